// File: doc/BRIEF.md
# External Interrupt Dispatcher

This block gathers the external interrupt sources of one processor and hands the core one interrupt at a time. There are three sources. Two are timer events: a clock-comparator event and a CPU-timer event. Each event sets a sticky pending bit. The third source is a last-in-first-out stack of interrupt records that software pushes. Each record carries a 16-bit code, a 32-bit parameter and a 64-bit parameter.

The block dispatches an interrupt only while the external mask is on and no other exception is being handled. It then picks the highest-priority source and loads a registered output that holds the code, both parameters and a CPU-address field. The core takes the output through a valid/ready handshake. The block also drives a hard-interrupt request line, which stays high for as long as any source has work pending.

Top module: `ext_irq_dispatch`

## Requirements
- R1: After a synchronous reset, `irq_valid`, `hard_req` and `ovf` are all 0 and the stack holds no records.
- R2: A pulse on `tod_evt` or `cpt_evt` sets that source's pending bit, and `hard_req` is 1 from the following clock edge. A pending bit stays set, however long the mask is off, until its interrupt is dispatched.
- R3: A new interrupt is loaded only on an edge where `ext_mask` is 1 and `exc_busy` is 0. On other edges `irq_valid` does not rise.
- R4: Priority is fixed. A stacked record goes first, then the clock-comparator event, then the CPU-timer event.
- R5: A dispatched clock-comparator event gives code 0x1004 and a dispatched CPU-timer event gives code 0x1005. In both cases `irq_p32` and `irq_p64` are 0.
- R6: Stacked records leave in reverse order of their pushes, and each one leaves exactly once. Every record keeps its code and both parameters unchanged.
- R7: `irq_cpu_addr` equals 0x0D00 bitwise-ORed with `cpu_num`, which is zero-extended to 16 bits.
- R8: `hard_req` tracks whether anything is pending. After a dispatch it falls to 0 if no pending bit and no stacked record remain, and it stays at 1 otherwise.
- R9: A push while the stack holds DEPTH records is dropped, and it sets `ovf`. `ovf` then stays 1 until reset. The stack still holds and later delivers exactly the DEPTH records it had before the push.
- R10: If a push and a stack dispatch fall on the same edge, the push is applied first. The record just pushed is the one dispatched, and the records beneath it stay in the stack.
- R11: While `irq_valid` is 1 and `irq_ready` is 0, the output holds all its fields unchanged and nothing is dispatched. The edge on which `irq_ready` is 1 completes the transfer, and the next interrupt may be loaded on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tod_evt | input | 1 | Clock-comparator event pulse |
| cpt_evt | input | 1 | CPU-timer event pulse |
| ext_mask | input | 1 | External interrupts enabled |
| exc_busy | input | 1 | Another exception is being handled |
| cpu_num | input | CPU_W | Number of this processor |
| push_valid | input | 1 | Push a record onto the stack |
| push_code | input | 16 | Interrupt code of the pushed record |
| push_p32 | input | 32 | 32-bit parameter of the pushed record |
| push_p64 | input | 64 | 64-bit parameter of the pushed record |
| irq_ready | input | 1 | Core accepts the presented interrupt |
| irq_valid | output | 1 | An interrupt is presented |
| irq_code | output | 16 | Interrupt code |
| irq_p32 | output | 32 | 32-bit parameter |
| irq_p64 | output | 64 | 64-bit parameter |
| irq_cpu_addr | output | 16 | CPU-address field |
| hard_req | output | 1 | Hard-interrupt request to the core |
| ovf | output | 1 | Sticky stack-overflow flag |

## Verification
The bench sweeps every stack fill from empty to full against all four combinations of timer events. It checks the full drain order each time, so a design with swapped priorities, or one that serves the stack first-in-first-out, would put records or timer codes in the wrong place. A push into a full stack is drained afterwards to confirm that the dropped record never appears and the old records are not corrupted. It also catches a stuck-at-zero overflow flag. Further scenarios hold `irq_ready` low to catch output fields that change or events that are lost during the wait. A push on the same edge as a dispatch catches a design that sends the older top record or loses the new one. Busy and mask gating catches a dispatch made during another exception.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int CODE_W = 16;
  localparam int P32_W  = 32;
  localparam int P64_W  = 64;

  localparam logic [CODE_W-1:0] TOD_CODE      = 16'h1004;
  localparam logic [CODE_W-1:0] CPT_CODE      = 16'h1005;
  localparam logic [15:0]       CPU_ADDR_BASE = 16'h0D00;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [P32_W-1:0]  p32;
    logic [P64_W-1:0]  p64;
  } xrec_t;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_STACK = 2'd1,
    SRC_TOD   = 2'd2,
    SRC_CPT   = 2'd3
  } src_e;

endpackage

// File: rtl/ext_irq_lifo.sv
module ext_irq_lifo
  import ext_irq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  xrec_t push_rec,
  input  logic  pop,
  output xrec_t head,
  output logic  avail,
  output logic  full,
  output logic  nz_next
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  xrec_t          mem [DEPTH];
  logic [CW-1:0]  cnt, cnt_n;
  logic [AW-1:0]  wr_idx, rd_idx;
  logic           push_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push & ~full;
  assign avail   = push_ok | (cnt != '0);
  assign wr_idx  = AW'(cnt);
  assign rd_idx  = AW'(cnt - CW'(1));

  // a push in the same cycle sits on top of the stack, so it is served first
  assign head = push_ok ? push_rec : mem[rd_idx];

  always_comb begin
    unique case ({push_ok, pop})
      2'b10:   cnt_n = cnt + CW'(1);
      2'b01:   cnt_n = cnt - CW'(1);
      default: cnt_n = cnt;
    endcase
  end

  assign nz_next = (cnt_n != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_idx] <= push_rec;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_n;
  end

endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb
  import ext_irq_pkg::*;
(
  input  logic stack_av,
  input  logic tod_pend,
  input  logic cpt_pend,
  output src_e sel
);

  always_comb begin
    if (stack_av)      sel = SRC_STACK;
    else if (tod_pend) sel = SRC_TOD;
    else if (cpt_pend) sel = SRC_CPT;
    else               sel = SRC_NONE;
  end

endmodule

// File: rtl/ext_irq_dispatch.sv
module ext_irq_dispatch
  import ext_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CPU_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tod_evt,
  input  logic              cpt_evt,
  input  logic              ext_mask,
  input  logic              exc_busy,
  input  logic [CPU_W-1:0]  cpu_num,
  input  logic              push_valid,
  input  logic [CODE_W-1:0] push_code,
  input  logic [P32_W-1:0]  push_p32,
  input  logic [P64_W-1:0]  push_p64,
  input  logic              irq_ready,
  output logic              irq_valid,
  output logic [CODE_W-1:0] irq_code,
  output logic [P32_W-1:0]  irq_p32,
  output logic [P64_W-1:0]  irq_p64,
  output logic [15:0]       irq_cpu_addr,
  output logic              hard_req,
  output logic              ovf
);

  xrec_t push_rec, head;
  logic  stack_av, stack_full, stack_nz_n;
  logic  tod_pend, cpt_pend, tod_pend_n, cpt_pend_n;
  logic  slot_free, go, pop;
  src_e  sel;

  assign push_rec = '{code: push_code, p32: push_p32, p64: push_p64};

  ext_irq_lifo #(.DEPTH(DEPTH)) u_lifo (
    .clk      (clk),
    .rst      (rst),
    .push     (push_valid),
    .push_rec (push_rec),
    .pop      (pop),
    .head     (head),
    .avail    (stack_av),
    .full     (stack_full),
    .nz_next  (stack_nz_n)
  );

  ext_irq_arb u_arb (
    .stack_av (stack_av),
    .tod_pend (tod_pend),
    .cpt_pend (cpt_pend),
    .sel      (sel)
  );

  assign slot_free = ~irq_valid | irq_ready;
  assign go        = ext_mask & ~exc_busy & slot_free & (sel != SRC_NONE);
  assign pop       = go & (sel == SRC_STACK);

  // a new event wins over the clear of the one being dispatched
  assign tod_pend_n = tod_evt | (tod_pend & ~(go & (sel == SRC_TOD)));
  assign cpt_pend_n = cpt_evt | (cpt_pend & ~(go & (sel == SRC_CPT)));

  always_ff @(posedge clk) begin
    if (rst) begin
      tod_pend <= 1'b0;
      cpt_pend <= 1'b0;
      hard_req <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      tod_pend <= tod_pend_n;
      cpt_pend <= cpt_pend_n;
      hard_req <= tod_pend_n | cpt_pend_n | stack_nz_n;
      ovf      <= ovf | (push_valid & stack_full);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid    <= 1'b0;
      irq_code     <= '0;
      irq_p32      <= '0;
      irq_p64      <= '0;
      irq_cpu_addr <= '0;
    end else if (go) begin
      irq_valid    <= 1'b1;
      irq_cpu_addr <= CPU_ADDR_BASE | 16'(cpu_num);
      unique case (sel)
        SRC_STACK: begin
          irq_code <= head.code;
          irq_p32  <= head.p32;
          irq_p64  <= head.p64;
        end
        SRC_TOD: begin
          irq_code <= TOD_CODE;
          irq_p32  <= '0;
          irq_p64  <= '0;
        end
        default: begin
          irq_code <= CPT_CODE;
          irq_p32  <= '0;
          irq_p64  <= '0;
        end
      endcase
    end else if (irq_ready) begin
      irq_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ext_irq_dispatch_chk.sv
module ext_irq_dispatch_chk
  import ext_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tod_evt,
  input logic              cpt_evt,
  input logic              ext_mask,
  input logic              exc_busy,
  input logic              irq_ready,
  input logic              irq_valid,
  input logic [CODE_W-1:0] irq_code,
  input logic [P32_W-1:0]  irq_p32,
  input logic [P64_W-1:0]  irq_p64,
  input logic [15:0]       irq_cpu_addr,
  input logic              hard_req,
  input logic              ovf
);

  p_evt_req_r2: assert property (@(posedge clk) disable iff (rst)
    (tod_evt || cpt_evt) |=> hard_req);

  p_gate_r3: assert property (@(posedge clk) disable iff (rst)
    ((!irq_valid || irq_ready) && !(ext_mask && !exc_busy)) |=> !irq_valid);

  p_cpu_addr_r7: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_cpu_addr[15:8] == CPU_ADDR_BASE[15:8]));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_ready) |=>
      (irq_valid && $stable(irq_code) && $stable(irq_p32) && $stable(irq_p64)));

endmodule

bind ext_irq_dispatch ext_irq_dispatch_chk u_chk (.*);

// File: tb/ext_irq_dispatch_test.sv
`timescale 1ns/1ps
module ext_irq_dispatch_test;
  import ext_irq_pkg::*;

  localparam int DEPTH = 4;
  localparam int CPU_W = 8;
  localparam logic [CPU_W-1:0] CPUN = 8'h2A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tod_evt = 0, cpt_evt = 0, ext_mask = 0, exc_busy = 0;
  logic [CPU_W-1:0] cpu_num = CPUN;
  logic push_valid = 0;
  logic [15:0] push_code = '0;
  logic [31:0] push_p32 = '0;
  logic [63:0] push_p64 = '0;
  logic irq_ready = 1'b1;
  logic irq_valid, hard_req, ovf;
  logic [15:0] irq_code, irq_cpu_addr;
  logic [31:0] irq_p32;
  logic [63:0] irq_p64;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  ext_irq_dispatch #(.DEPTH(DEPTH), .CPU_W(CPU_W)) uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic xrec_t mkrec(input int salt, input int k);
    xrec_t r;
    r.code = 16'hA000 | 16'((salt & 255) << 4) | 16'(k & 15);
    r.p32  = 32'hC0DE0000 + 32'(r.code);
    r.p64  = {r.p32, ~r.p32};
    return r;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push_one(input xrec_t r);
    push_valid = 1; push_code = r.code; push_p32 = r.p32; push_p64 = r.p64;
    tick();
    push_valid = 0;
  endtask

  task automatic chk_rec(input string req, input xrec_t e);
    chk(irq_valid === 1'b1, req, "valid", 64'(irq_valid), 64'd1);
    chk(irq_code === e.code, req, "code", 64'(irq_code), 64'(e.code));
    chk(irq_p32 === e.p32, req, "p32", 64'(irq_p32), 64'(e.p32));
    chk(irq_p64 === e.p64, req, "p64", irq_p64, e.p64);
    chk(irq_cpu_addr === (16'h0D00 | 16'(CPUN)), "R7", "cpu_addr",
        64'(irq_cpu_addr), 64'(16'h0D00 | 16'(CPUN)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    xrec_t e;
    xrec_t ex [$];
    int got;
    repeat (2) tick();
    rst = 0;
    chk(irq_valid === 1'b0, "R1", "valid after reset", 64'(irq_valid), 0);
    chk(hard_req === 1'b0, "R1", "hard_req after reset", 64'(hard_req), 0);
    chk(ovf === 1'b0, "R1", "ovf after reset", 64'(ovf), 0);

    // sweep: stack fill 0..DEPTH x timer combination (R2 R3 R4 R5 R6 R8)
    for (int n = 0; n <= DEPTH; n++) begin
      for (int t = 0; t < 4; t++) begin
        ex.delete();
        for (int k = 0; k < n; k++) push_one(mkrec(n * 4 + t, k));
        tod_evt = t[0]; cpt_evt = t[1];
        tick();
        tod_evt = 0; cpt_evt = 0;
        chk(hard_req === ((n > 0) || (t != 0)), "R2", "hard_req pending",
            64'(hard_req), 64'((n > 0) || (t != 0)));
        repeat (3) tick();
        chk(irq_valid === 1'b0, "R3", "no dispatch with mask off", 64'(irq_valid), 0);
        for (int k = n - 1; k >= 0; k--) ex.push_back(mkrec(n * 4 + t, k));
        if (t[0]) begin e.code = TOD_CODE; e.p32 = '0; e.p64 = '0; ex.push_back(e); end
        if (t[1]) begin e.code = CPT_CODE; e.p32 = '0; e.p64 = '0; ex.push_back(e); end
        got = 0;
        ext_mask = 1;
        repeat (n + 5) begin
          tick();
          if (irq_valid) begin
            if (got < ex.size()) chk_rec("R4_R5_R6 order", ex[got]);
            got++;
          end
        end
        chk(got == ex.size(), "R6", "dispatch count", 64'(got), 64'(ex.size()));
        chk(hard_req === 1'b0, "R8", "hard_req after drain", 64'(hard_req), 0);
        ext_mask = 0;
      end
    end

    // R3: busy blocks dispatch
    push_one(mkrec(99, 1));
    ext_mask = 1; exc_busy = 1;
    repeat (3) begin
      tick();
      chk(irq_valid === 1'b0, "R3", "no dispatch while busy", 64'(irq_valid), 0);
    end
    exc_busy = 0;
    tick();
    chk_rec("R3 after busy", mkrec(99, 1));
    tick();
    ext_mask = 0;

    // R11 + R8: hold while not ready, hard_req stays with work left
    irq_ready = 0;
    push_one(mkrec(77, 2));
    tod_evt = 1; tick(); tod_evt = 0;
    ext_mask = 1;
    tick();
    chk_rec("R11 first", mkrec(77, 2));
    chk(hard_req === 1'b1, "R8", "hard_req with timer left", 64'(hard_req), 1);
    repeat (3) begin
      tick();
      chk_rec("R11 held", mkrec(77, 2));
    end
    irq_ready = 1;
    tick();
    e.code = TOD_CODE; e.p32 = '0; e.p64 = '0;
    chk_rec("R11 next after handshake", e);
    chk(hard_req === 1'b0, "R8", "hard_req after last", 64'(hard_req), 0);
    tick();
    chk(irq_valid === 1'b0, "R11", "valid drops", 64'(irq_valid), 0);
    ext_mask = 0;

    // R10: push on the dispatch edge
    push_one(mkrec(55, 0));
    push_one(mkrec(55, 1));
    ext_mask = 1;
    push_one(mkrec(55, 2));
    chk_rec("R10 pushed record first", mkrec(55, 2));
    tick(); chk_rec("R10 below 1", mkrec(55, 1));
    tick(); chk_rec("R10 below 0", mkrec(55, 0));
    tick();
    chk(irq_valid === 1'b0, "R10", "stack empty", 64'(irq_valid), 0);
    ext_mask = 0;

    // R9: overflow
    chk(ovf === 1'b0, "R9", "ovf clear before", 64'(ovf), 0);
    for (int k = 0; k < DEPTH + 2; k++) push_one(mkrec(33, k));
    chk(ovf === 1'b1, "R9", "ovf set", 64'(ovf), 1);
    ext_mask = 1;
    got = 0;
    repeat (DEPTH + 4) begin
      tick();
      if (irq_valid) begin
        if (got < DEPTH) chk_rec("R9 kept records", mkrec(33, DEPTH - 1 - got));
        got++;
      end
    end
    chk(got == DEPTH, "R9", "records after overflow", 64'(got), 64'(DEPTH));
    chk(ovf === 1'b1, "R9", "ovf sticky", 64'(ovf), 1);
    ext_mask = 0;
    rst = 1; tick(); rst = 0;
    chk(ovf === 1'b0, "R1", "ovf cleared by reset", 64'(ovf), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule